// File: doc/BRIEF.md
# Programmable FIFO Fill-State Flag Encoder

This block sits beside the storage array of a first-in first-out buffer and turns the current word count into three registered status outputs. The three outputs together describe six fill states: empty, near empty, at or below half, above half, near full and full. No single output names a state on its own. The half output separates the lower half from the upper half. The bound output is low only at the two extremes. The margin output is high only in the central band. A consumer decodes all three to tell the states apart.

The width of the near-empty and near-full bands is a threshold P, chosen by a 4-bit code. That code can only be written while master reset is held. It can come from the write-side data bus on a write strobe or from the read-side bus on a read strobe. Any reset in which no load happens returns the threshold to 256 words. The depth N is a parameter. The storage array, the read and write pointers and any output drivers are outside this block.

Top module: `fifo_fill_flags`

## Requirements
- R1: The output triple {flag_half, flag_bound, flag_margin} is 3'b100 for empty, 3'b110 for near empty, 3'b111 for at-or-below half, 3'b011 for above half, 3'b010 for near full and 3'b000 for full. The patterns 3'b101 and 3'b001 never appear.
- R2: With threshold P and depth N, the states are decided by the count as follows. A count of 0 is empty and 1 to P-1 is near empty. P to N/2 is at-or-below half and N/2+1 to N-P is above half. N-P+1 to N-1 is near full, and a count of N or more is full.
- R3: A code c from 4'b0001 to 4'b1000 selects P = 16 << (c-1), giving 16 up to 2048. Codes 4'b0000 and 4'b0101 both select 256.
- R4: Code 4'b1001 selects P = 4098 when DEPTH is greater than 8192. At smaller depths it selects 256.
- R5: Codes 4'b1010 to 4'b1111 select 256.
- R6: Strobes seen while rst is low leave the threshold unchanged.
- R7: While rst is high, wr_stb loads the code from wr_code. Otherwise rd_stb loads it from rd_code. When both strobes are high in the same cycle, wr_code is taken.
- R8: Each reset begins from the default code, so a reset with no load gives P = 256. When several loads happen in one reset, the last one is kept after rst falls.
- R9: While rst is high, the outputs show 3'b100 one cycle after the edge, whatever the count.
- R10: The outputs are registered. They reflect the count and threshold sampled at the previous rising edge and do not follow fill_count within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset; also opens the threshold load window |
| fill_count | input | $clog2(DEPTH+1) | Current number of stored words |
| wr_stb | input | 1 | Write-side strobe; loads the threshold code during reset |
| rd_stb | input | 1 | Read-side strobe; loads the threshold code during reset |
| wr_code | input | 4 | Low four bits of the write-side data bus |
| rd_code | input | 4 | Low four bits of the read-side data bus |
| flag_half | output | 1 | High while the count is at most N/2 |
| flag_bound | output | 1 | Low when empty or full |
| flag_margin | output | 1 | High only between the near-empty and near-full bands |

## Verification
The bench checks the count exactly on each side of every boundary (P-1/P, N/2 and N/2+1, N-P and N-P+1, N-1 and N) for every code. An off-by-one comparison therefore shows up as a wrong pattern at one specific count. Code 4'b1001 is applied to a deep instance and to an 8K instance, and the last six codes are applied too. A threshold decoder that guards the wrong code or the wrong depth gives a band edge in the wrong place. The bench also covers strobes outside reset, both strobes in one cycle, two loads in one reset and a reset with no load. A register that ignores the reset window, has the wrong priority, or fails to return to the default would shift the near-empty edge. A check right after fill_count changes, before the next edge, catches flags that are combinational instead of registered.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_DEFAULT = 4'b0000;
  localparam int unsigned THRESH_DEFAULT = 256;
  localparam int unsigned THRESH_WIDE = 4098;
  localparam int unsigned WIDE_DEPTH_MIN = 8192;

  typedef enum logic [2:0] {
    FILL_EMPTY,
    FILL_LOW_BAND,
    FILL_BELOW_HALF,
    FILL_ABOVE_HALF,
    FILL_HIGH_BAND,
    FILL_FULL
  } fill_state_e;

  typedef struct packed {
    logic half;
    logic bound;
    logic margin;
  } flag_triple_t;

  localparam flag_triple_t TRIPLE_EMPTY = '{half: 1'b1, bound: 1'b0, margin: 1'b0};

  function automatic flag_triple_t encode_state(input fill_state_e st);
    flag_triple_t t;
    unique case (st)
      FILL_EMPTY:      t = '{half: 1'b1, bound: 1'b0, margin: 1'b0};
      FILL_LOW_BAND:   t = '{half: 1'b1, bound: 1'b1, margin: 1'b0};
      FILL_BELOW_HALF: t = '{half: 1'b1, bound: 1'b1, margin: 1'b1};
      FILL_ABOVE_HALF: t = '{half: 1'b0, bound: 1'b1, margin: 1'b1};
      FILL_HIGH_BAND:  t = '{half: 1'b0, bound: 1'b1, margin: 1'b0};
      default:         t = '{half: 1'b0, bound: 1'b0, margin: 1'b0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/flag_offset_reg.sv
module flag_offset_reg
  import fifo_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] rd_code,
  output logic [CODE_W-1:0] code_q
);

  // Previous reset level; a low-to-high step opens a fresh load window.
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      if (wr_stb)       code_q <= wr_code;
      else if (rd_stb)  code_q <= rd_code;
      else if (!rst_q)  code_q <= CODE_DEFAULT;
    end
  end

  // R6: outside the reset window the code must not move
  assert_hold_outside_reset_R6: assert property (
    @(posedge clk) disable iff (rst) (!rst) |=> $stable(code_q));

endmodule

// File: rtl/flag_thresh_decode.sv
module flag_thresh_decode
  import fifo_flag_pkg::*;
#(
  parameter int unsigned DEPTH = 8192,
  parameter int TW = 16
)(
  input  logic [CODE_W-1:0] code,
  output logic [TW-1:0]     thresh
);

  logic [31:0] base_p;
  logic [31:0] full_p;

  always_comb begin
    if (code >= 4'd1 && code <= 4'd8)
      base_p = 32'd16 << (32'(code) - 32'd1);
    else
      base_p = THRESH_DEFAULT;
  end

  generate
    if (DEPTH > WIDE_DEPTH_MIN) begin : g_wide
      always_comb full_p = (code == 4'd9) ? THRESH_WIDE : base_p;
    end else begin : g_narrow
      always_comb full_p = base_p;
    end
  endgenerate

  assign thresh = TW'(full_p);

  // R3/R4: threshold is a power of two or the wide special value
  always_comb begin
    if (!$isunknown(code))
      assert_thresh_shape_R3: assert ($countones(thresh) == 1 || 32'(thresh) == THRESH_WIDE);
  end

endmodule

// File: rtl/flag_state_classify.sv
module flag_state_classify
  import fifo_flag_pkg::*;
#(
  parameter int unsigned DEPTH = 8192,
  parameter int CW = 14,
  parameter int TW = 16
)(
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thresh,
  output fill_state_e   state
);

  localparam logic [31:0] N    = 32'(DEPTH);
  localparam logic [31:0] HALF = 32'(DEPTH / 2);

  logic [31:0] c;
  logic [31:0] p;
  logic [31:0] hi_edge;

  always_comb begin
    c = 32'(count);
    p = 32'(thresh);
    hi_edge = (p > N) ? 32'd0 : (N - p);
    if (c == 32'd0)        state = FILL_EMPTY;
    else if (c >= N)       state = FILL_FULL;
    else if (c < p)        state = FILL_LOW_BAND;
    else if (c <= HALF)    state = FILL_BELOW_HALF;
    else if (c <= hi_edge) state = FILL_ABOVE_HALF;
    else                   state = FILL_HIGH_BAND;
  end

endmodule

// File: rtl/fifo_fill_flags.sv
module fifo_fill_flags
  import fifo_flag_pkg::*;
#(
  parameter int unsigned DEPTH = 8192,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = (CW > 13) ? CW : 13
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     fill_count,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] rd_code,
  output logic              flag_half,
  output logic              flag_bound,
  output logic              flag_margin
);

  logic [CODE_W-1:0] code_q;
  logic [TW-1:0]     thresh;
  fill_state_e       state;
  flag_triple_t      triple_q;

  flag_offset_reg u_offset (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .wr_code (wr_code),
    .rd_code (rd_code),
    .code_q  (code_q)
  );

  flag_thresh_decode #(.DEPTH(DEPTH), .TW(TW)) u_decode (
    .code   (code_q),
    .thresh (thresh)
  );

  flag_state_classify #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) u_classify (
    .count  (fill_count),
    .thresh (thresh),
    .state  (state)
  );

  always_ff @(posedge clk) begin
    if (rst) triple_q <= TRIPLE_EMPTY;
    else     triple_q <= encode_state(state);
  end

  assign flag_half   = triple_q.half;
  assign flag_bound  = triple_q.bound;
  assign flag_margin = triple_q.margin;

  // R1: the two unused patterns never show
  assert_legal_pattern_R1: assert property (
    @(posedge clk) disable iff (rst)
      !({flag_half, flag_bound, flag_margin} == 3'b101 ||
        {flag_half, flag_bound, flag_margin} == 3'b001));

  // R2: zero count gives the empty pattern one edge later
  assert_empty_count_R2: assert property (
    @(posedge clk) disable iff (rst)
      (fill_count == '0) |=> ({flag_half, flag_bound, flag_margin} == 3'b100));

  // R2: a count at depth gives the full pattern one edge later
  assert_full_count_R2: assert property (
    @(posedge clk) disable iff (rst)
      (32'(fill_count) >= 32'(DEPTH)) |=> ({flag_half, flag_bound, flag_margin} == 3'b000));

  // R10: a steady count outside reset keeps the flags steady
  assert_steady_flags_R10: assert property (
    @(posedge clk) disable iff (rst)
      ($stable(fill_count) && !$past(rst)) |=> $stable({flag_half, flag_bound, flag_margin}));

endmodule

// File: tb/fifo_fill_flags_test.sv
module fifo_fill_flags_test;

  localparam int unsigned DEEP  = 16384;
  localparam int unsigned SHORT = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [3:0]  wr_code = 4'd0, rd_code = 4'd0;
  logic [14:0] cnt_deep = '0;
  logic [13:0] cnt_short = '0;
  logic        h1, b1, m1, h2, b2, m2;

  int total = 0;
  int bad = 0;
  int p_deep = 256;
  int p_short = 256;

  always #4 clk = ~clk;

  fifo_fill_flags #(.DEPTH(DEEP)) uut (
    .clk(clk), .rst(rst), .fill_count(cnt_deep), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_code(wr_code), .rd_code(rd_code),
    .flag_half(h1), .flag_bound(b1), .flag_margin(m1));

  fifo_fill_flags #(.DEPTH(SHORT)) uut_short (
    .clk(clk), .rst(rst), .fill_count(cnt_short), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_code(wr_code), .rd_code(rd_code),
    .flag_half(h2), .flag_bound(b2), .flag_margin(m2));

  function automatic int exp_p(input logic [3:0] c, input int n);
    if (c >= 4'd1 && c <= 4'd8) return 16 << (int'(c) - 1);
    if (c == 4'd9 && n > 8192) return 4098;
    return 256;
  endfunction

  function automatic logic [2:0] exp_flags(input int cnt, input int p, input int n);
    if (cnt == 0)        return 3'b100;
    if (cnt >= n)        return 3'b000;
    if (cnt < p)         return 3'b110;
    if (cnt <= n / 2)    return 3'b111;
    if (cnt <= n - p)    return 3'b011;
    return 3'b010;
  endfunction

  task automatic judge(input logic [2:0] got, input logic [2:0] exp, input string req, input int cnt);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s count=%0d got=%b exp=%b", req, cnt, got, exp);
    end
  endtask

  // Applies a count, waits one edge, checks both instances.
  task automatic chk(input int cnt, input string req);
    int cs;
    @(negedge clk);
    cs = (cnt > int'(SHORT)) ? int'(SHORT) : cnt;
    cnt_deep = 15'(cnt);
    cnt_short = 14'(cs);
    @(negedge clk);
    judge({h1, b1, m1}, exp_flags(cnt, p_deep, DEEP), req, cnt);
    judge({h2, b2, m2}, exp_flags(cs, p_short, SHORT), req, cs);
  endtask

  // Reset with up to two loads; src 0 = write side, 1 = read side.
  task automatic reset_load(input int n, input logic [3:0] ca, input bit sa,
                            input logic [3:0] cb, input bit sb);
    @(negedge clk);
    rst = 1'b1;
    cnt_deep = 15'd9000;
    cnt_short = 14'd5000;
    wr_code = sa ? ~ca : ca;  rd_code = sa ? ca : ~ca;
    wr_stb = (n >= 1) && !sa; rd_stb = (n >= 1) && sa;
    @(negedge clk);
    wr_code = sb ? ~cb : cb;  rd_code = sb ? cb : ~cb;
    wr_stb = (n >= 2) && !sb; rd_stb = (n >= 2) && sb;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    // R9: flags show empty during reset despite a large count
    judge({h1, b1, m1}, 3'b100, "R9", 9000);
    judge({h2, b2, m2}, 3'b100, "R9", 5000);
    rst = 1'b0;
    if (n == 0)      begin p_deep = 256;            p_short = 256; end
    else if (n == 1) begin p_deep = exp_p(ca, DEEP); p_short = exp_p(ca, SHORT); end
    else             begin p_deep = exp_p(cb, DEEP); p_short = exp_p(cb, SHORT); end
  endtask

  task automatic sweep(input string req);
    chk(0, req); chk(1, req); chk(p_deep - 1, req); chk(p_deep, req);
    chk(DEEP / 2, req); chk(DEEP / 2 + 1, req);
    chk(DEEP - p_deep, req); chk(DEEP - p_deep + 1, req);
    chk(DEEP - 1, req); chk(DEEP, req);
    chk(p_short - 1, req); chk(p_short, req);
    chk(SHORT - p_short, req); chk(SHORT - p_short + 1, req);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 and R8: plain reset, default threshold
    reset_load(0, 4'd0, 1'b0, 4'd0, 1'b0);
    sweep("R2");
    // R1: each of the six patterns at a chosen count
    chk(0, "R1"); chk(100, "R1"); chk(3000, "R1"); chk(9000, "R1"); chk(16300, "R1"); chk(16384, "R1");

    // R10: flags do not follow the count before the edge
    chk(0, "R10");
    @(negedge clk);
    cnt_deep = 15'd16384;
    #1 judge({h1, b1, m1}, 3'b100, "R10", 16384);
    @(negedge clk);
    judge({h1, b1, m1}, 3'b000, "R10", 16384);

    // R3/R4/R5: every code via the write side
    for (int c = 0; c < 16; c++) begin
      reset_load(1, 4'(c), 1'b0, 4'd0, 1'b0);
      chk(p_deep - 1, (c == 9) ? "R4" : (c >= 10) ? "R5" : "R3");
      chk(p_deep, (c == 9) ? "R4" : (c >= 10) ? "R5" : "R3");
      chk(p_short - 1, (c == 9) ? "R4" : (c >= 10) ? "R5" : "R3");
      chk(p_short, (c == 9) ? "R4" : (c >= 10) ? "R5" : "R3");
    end

    // R7: read-side load
    reset_load(1, 4'd7, 1'b1, 4'd0, 1'b0);
    chk(1023, "R7"); chk(1024, "R7"); chk(DEEP - 1024 + 1, "R7");

    // R7: both strobes together, write side wins
    @(negedge clk);
    rst = 1'b1; wr_stb = 1'b1; rd_stb = 1'b1; wr_code = 4'd1; rd_code = 4'd7;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    @(negedge clk);
    rst = 1'b0; p_deep = 16; p_short = 16;
    chk(15, "R7"); chk(16, "R7");

    // R6: strobes outside reset are ignored
    @(negedge clk);
    wr_stb = 1'b1; rd_stb = 1'b1; wr_code = 4'd7; rd_code = 4'd8;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk(15, "R6"); chk(16, "R6"); chk(DEEP - 16 + 1, "R6");

    // R8: last of two loads kept, then default again on bare reset
    reset_load(2, 4'd3, 1'b0, 4'd6, 1'b1);
    chk(511, "R8"); chk(512, "R8"); chk(DEEP - 512, "R8"); chk(DEEP - 511, "R8");
    reset_load(0, 4'd0, 1'b0, 4'd0, 1'b0);
    chk(255, "R8"); chk(256, "R8");

    // Random counts near boundaries, with random reloads
    for (int i = 0; i < 600; i++) begin
      int sel;
      int cnt;
      if (($urandom % 40) == 0) begin
        reset_load(1 + int'($urandom % 2), 4'($urandom), 1'($urandom),
                   4'($urandom), 1'($urandom));
      end
      sel = int'($urandom % 12);
      case (sel)
        0: cnt = 0;
        1: cnt = 1;
        2: cnt = p_deep - 1;
        3: cnt = p_deep;
        4: cnt = DEEP / 2;
        5: cnt = DEEP / 2 + 1;
        6: cnt = DEEP - p_deep;
        7: cnt = DEEP - p_deep + 1;
        8: cnt = DEEP - 1;
        9: cnt = DEEP;
        default: cnt = int'($urandom % (DEEP + 1));
      endcase
      chk(cnt, "R2");
    end

    finish_run();
  end

endmodule